// File: doc/BRIEF.md
# Normal Basis Field Multiplier

This block multiplies two elements of the binary field GF(2^261). Each element is a 261-bit vector of coefficients over an optimal normal basis of type II (2·261+1 = 523 is prime). Bit i of a vector is the coefficient of the basis element β^(2^i). The product is built one coefficient per clock step. Both operands sit in registers that rotate by one position each step. A fixed wiring of AND terms, whose index pattern is computed at elaboration, feeds a radix-3 XOR reduction tree. One register stage cuts that tree at its 87-wide level.

A `start` pulse with `sq_sel` low loads both operands and begins a multiply. Coefficients enter a result shift register from the top, and `done` pulses once the last one lands. A `start` pulse with `sq_sel` high squares `op_a`. In a normal basis, squaring is a one-place cyclic rotation, so it finishes in a single cycle. The result holds its value until the next accepted `start`. A `start` that arrives during a multiply is ignored.

Top module: `nbm_mult`

## Requirements
- R1: After reset, `result` is all zeros and `done` is low.
- R2: A `start` pulse with `sq_sel` = 0 while idle yields, in `result`, the normal-basis product of `op_a` and `op_b`. Bit i is the coefficient of β^(2^i), where β^(2^i) = γ^(2^i) + γ^(-2^i) and γ is a primitive 523rd root of unity. `done` rises 262 clock edges after the edge that sampled `start`.
- R3: Multiplying any element by the all-ones vector, in either operand position, returns that element unchanged.
- R4: A `start` pulse with `sq_sel` = 1 while idle sets `result` to `op_a` rotated up by one place: bit i+1 takes bit i, and bit 0 takes bit 260. `done` is high in the very next cycle.
- R5: `done` is high for exactly one cycle per operation and never while a multiply is running.
- R6: While idle and without `start`, `result` keeps its value, whatever `op_a`, `op_b` and `sq_sel` do.
- R7: A `start` pulse during a multiply is ignored. The running product finishes on its original schedule with its original operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request to begin an operation |
| sq_sel | input | 1 | With `start`: 1 squares `op_a`, 0 multiplies `op_a` by `op_b` |
| op_a | input | 261 | First operand, normal-basis coefficients |
| op_b | input | 261 | Second operand, normal-basis coefficients |
| result | output | 261 | Product or square, normal-basis coefficients |
| done | output | 1 | One-cycle pulse when `result` is complete |

## Verification
A multiply finishes 262 edges after the edge that samples `start`. That is 261 coefficient steps plus one for the register in the middle of the tree. A square finishes one edge after its `start`. The bench drives inputs on falling edges and counts falling edges after the `start` edge. For a multiply, it confirms that `done` stays low through the first 261 of them, then checks `done` and `result` at the 262nd and checks the drop of `done` at the 263rd. Products are compared with a reference in the bench that multiplies the two operands as polynomials modulo x^523 − 1 and reads the coefficients at the exponents 2^k mod 523.

// File: rtl/nbm_pkg.sv
`timescale 1ns/1ps
package nbm_pkg;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} nbm_state_e;

  // Index j with 2^j == +-(2^i + 1) (sel 0) or +-(2^i - 1) (sel 1) mod 2m+1;
  // -1 when the target is zero.
  function automatic int nb_cross(int m, int i, int sel);
    int p, t, tgt, v;
    p = 2 * m + 1;
    t = 1;
    for (int n = 0; n < i; n++) t = (t * 2) % p;
    tgt = (sel == 0) ? (t + 1) % p : (t + p - 1) % p;
    if (tgt == 0) return -1;
    v = 1;
    for (int j = 0; j < m; j++) begin
      if (v == tgt || v == p - tgt) return j;
      v = (v * 2) % p;
    end
    return -1;
  endfunction

  // Width after a number of radix-3 layers.
  function automatic int xr_width(int n0, int layers);
    int w;
    w = n0;
    for (int l = 0; l < layers; l++) w = (w + 2) / 3;
    return w;
  endfunction

  // Number of radix-3 layers to reach a single signal.
  function automatic int xr_levels(int n0);
    int w, l;
    w = n0;
    l = 0;
    while (w > 1) begin
      w = (w + 2) / 3;
      l++;
    end
    return l;
  endfunction

endpackage

// File: rtl/nbm_term_array.sv
`timescale 1ns/1ps
module nbm_term_array #(
  parameter int M = 261
) (
  input  logic [M-1:0] ra,
  input  logic [M-1:0] rb,
  output logic [M-1:0] term
);
  // One three-input cell per index of the rotated first operand.
  for (genvar i = 0; i < M; i++) begin : g_cell
    localparam int JA = nbm_pkg::nb_cross(M, i, 0);
    localparam int JB = nbm_pkg::nb_cross(M, i, 1);
    if (JB < 0) begin : g_single
      assign term[i] = ra[i] & rb[JA];
    end else begin : g_pair
      assign term[i] = ra[i] & (rb[JA] ^ rb[JB]);
    end
  end
endmodule

// File: rtl/nbm_xor3_reduce.sv
`timescale 1ns/1ps
module nbm_xor3_reduce #(
  parameter int N_IN   = 261,
  parameter int LAYERS = 1,
  localparam int N_OUT = nbm_pkg::xr_width(N_IN, LAYERS),
  localparam int PADW  = 3 * N_IN + 3
) (
  input  logic [N_IN-1:0]  din,
  output logic [N_OUT-1:0] dout
);
  logic [PADW-1:0] cur;
  logic [PADW-1:0] nxt;

  always_comb begin
    cur = '0;
    cur[N_IN-1:0] = din;
    for (int l = 0; l < LAYERS; l++) begin
      nxt = '0;
      for (int k = 0; k < N_IN; k++) begin
        if (k < nbm_pkg::xr_width(N_IN, l + 1)) begin
          nxt[k] = cur[3*k] ^ cur[3*k+1] ^ cur[3*k+2];
        end
      end
      cur = nxt;
    end
    dout = cur[N_OUT-1:0];
  end
endmodule

// File: rtl/nbm_mult.sv
`timescale 1ns/1ps
module nbm_mult #(
  parameter int M     = 261,
  parameter int SPLIT = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         sq_sel,
  input  logic [M-1:0] op_a,
  input  logic [M-1:0] op_b,
  output logic [M-1:0] result,
  output logic         done
);
  import nbm_pkg::*;

  localparam int MID   = xr_width(M, SPLIT);
  localparam int LEV_B = xr_levels(MID);
  localparam int CW    = $clog2(M + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q_n = rs_q[1];

  nbm_state_e     state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [M-1:0]   ra_q, ra_d, rb_q, rb_d;
  logic           ab_en;
  logic [MID-1:0] s1_q;
  logic           s1_en;
  logic           s1_vld_q, s1_vld_d;
  logic           s1_last_q, s1_last_d;
  logic [M-1:0]   res_q, res_d;
  logic           res_en;
  logic           done_q, done_d;
  logic           busy;

  logic [M-1:0]   term;
  logic [MID-1:0] part;
  logic [0:0]     coef;

  nbm_term_array #(.M(M)) u_terms (
    .ra   (ra_q),
    .rb   (rb_q),
    .term (term)
  );

  nbm_xor3_reduce #(.N_IN(M), .LAYERS(SPLIT)) u_tree_a (
    .din  (term),
    .dout (part)
  );

  nbm_xor3_reduce #(.N_IN(MID), .LAYERS(LEV_B)) u_tree_b (
    .din  (s1_q),
    .dout (coef)
  );

  assign busy = (state_q == ST_RUN);

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    ab_en     = 1'b0;
    ra_d      = ra_q;
    rb_d      = rb_q;
    s1_en     = 1'b0;
    s1_vld_d  = 1'b0;
    s1_last_d = 1'b0;
    res_en    = 1'b0;
    res_d     = res_q;
    done_d    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (sq_sel) begin
            res_en = 1'b1;
            res_d  = {op_a[M-2:0], op_a[M-1]};
            done_d = 1'b1;
          end else begin
            state_d = ST_RUN;
            cnt_d   = '0;
            ab_en   = 1'b1;
            ra_d    = op_a;
            rb_d    = op_b;
          end
        end
      end
      ST_RUN: begin
        if (cnt_q != CW'(M)) begin
          s1_en     = 1'b1;
          s1_vld_d  = 1'b1;
          s1_last_d = (cnt_q == CW'(M - 1));
          ab_en     = 1'b1;
          ra_d      = {ra_q[0], ra_q[M-1:1]};
          rb_d      = {rb_q[0], rb_q[M-1:1]};
          cnt_d     = cnt_q + 1'b1;
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (s1_vld_q) begin
      res_en = 1'b1;
      res_d  = {coef[0], res_q[M-1:1]};
      done_d = s1_last_q;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      s1_vld_q  <= 1'b0;
      s1_last_q <= 1'b0;
      res_q     <= '0;
      done_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      s1_vld_q  <= s1_vld_d;
      s1_last_q <= s1_last_d;
      done_q    <= done_d;
      if (res_en) res_q <= res_d;
    end
  end

  // datapath registers without reset
  always_ff @(posedge clk) begin
    if (ab_en) begin
      ra_q <= ra_d;
      rb_q <= rb_d;
    end
    if (s1_en) s1_q <= part;
  end

  assign result = res_q;
  assign done   = done_q;
endmodule

// File: rtl/nbm_mult_chk.sv
`timescale 1ns/1ps
module nbm_mult_chk #(
  parameter int M = 261
) (
  input logic         clk,
  input logic         rst_q_n,
  input logic         start,
  input logic         sq_sel,
  input logic         busy,
  input logic [M-1:0] op_a,
  input logic [M-1:0] result,
  input logic         done
);
  AST_SQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_q_n)
    !busy && start && sq_sel |=> done && result == {$past(op_a[M-2:0]), $past(op_a[M-1])}); // R4

  AST_MUL_ENTERS_RUN: assert property (@(posedge clk) disable iff (!rst_q_n)
    !busy && start && !sq_sel |=> busy && !done); // R2

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_q_n)
    done |-> !busy); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_q_n)
    done && !(start && sq_sel) |=> !done); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    !busy && !start |=> $stable(result)); // R6

  AST_BUSY_START_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_q_n)
    busy && start |=> busy || done); // R7
endmodule

bind nbm_mult nbm_mult_chk #(.M(M)) u_chk (
  .clk     (clk),
  .rst_q_n (rst_q_n),
  .start   (start),
  .sq_sel  (sq_sel),
  .busy    (busy),
  .op_a    (op_a),
  .result  (result),
  .done    (done)
);

// File: tb/sim_nbm_mult.sv
`timescale 1ns/1ps
module sim_nbm_mult;
  localparam int M   = 261;
  localparam int P   = 2 * M + 1;
  localparam int LAT = 262;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic         sq_sel;
  logic [M-1:0] op_a;
  logic [M-1:0] op_b;
  logic [M-1:0] result;
  logic         done;

  int n_chk;
  int n_bad;
  bit finished;

  nbm_mult #(.M(M)) u0 (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .sq_sel (sq_sel),
    .op_a   (op_a),
    .op_b   (op_b),
    .result (result),
    .done   (done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // product as polynomials modulo x^P - 1, read back at exponents 2^k
  function automatic logic [M-1:0] ref_mul(logic [M-1:0] a, logic [M-1:0] b);
    logic [P-1:0] pa, pb, pp;
    logic [M-1:0] c;
    int e;
    pa = '0; pb = '0; pp = '0;
    e = 1;
    for (int i = 0; i < M; i++) begin
      pa[e] = pa[e] ^ a[i]; pa[P-e] = pa[P-e] ^ a[i];
      pb[e] = pb[e] ^ b[i]; pb[P-e] = pb[P-e] ^ b[i];
      e = (e * 2) % P;
    end
    for (int s = 0; s < P; s++)
      if (pa[s]) pp = pp ^ ((pb << s) | (pb >> (P - s)));
    e = 1;
    for (int k = 0; k < M; k++) begin
      c[k] = pp[e];
      e = (e * 2) % P;
    end
    return c;
  endfunction

  function automatic logic [M-1:0] rnd_elem();
    logic [287:0] t;
    for (int w = 0; w < 9; w++) t[32*w +: 32] = $urandom;
    return t[M-1:0];
  endfunction

  task automatic chk_vec(string req, logic [M-1:0] act, logic [M-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_bit(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Multiply with exact latency check; optional busy-time start at step `poke`.
  task automatic run_mul(string req, logic [M-1:0] a, logic [M-1:0] b, int poke);
    logic [M-1:0] exp;
    logic early;
    exp = ref_mul(a, b);
    @(negedge clk);
    start = 1'b1; sq_sel = 1'b0; op_a = a; op_b = b;
    @(negedge clk);
    start = 1'b0; op_a = ~a; op_b = rnd_elem();
    early = 1'b0;
    for (int n = 1; n < LAT; n++) begin
      @(negedge clk);
      if (done) early = 1'b1;
      if (n == poke) begin
        start = 1'b1; sq_sel = 1'b1; op_a = rnd_elem();
      end else begin
        start = 1'b0;
      end
    end
    chk_bit({req, " done stays low before due edge"}, early, 1'b0);
    @(negedge clk);
    chk_bit({req, " done at edge 262"}, done, 1'b1);
    chk_vec({req, " product"}, result, exp);
    @(negedge clk);
    chk_bit({req, " R5 done falls"}, done, 1'b0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; sq_sel = 1'b0; op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_vec("R1 result after reset", result, '0);
    chk_bit("R1 done after reset", done, 1'b0);
  endtask

  task automatic t_products();
    logic [M-1:0] one;
    one = '0; one[0] = 1'b1;
    run_mul("R2 random pair", rnd_elem(), rnd_elem(), -1);
    run_mul("R2 random pair b", rnd_elem(), rnd_elem(), -1);
    run_mul("R2 single basis elements", one, one << 7, -1);
    run_mul("R2 top bit times random", one << (M - 1), rnd_elem(), -1);
    run_mul("R2 zero operand", '0, rnd_elem(), -1);
  endtask

  task automatic t_identity();
    logic [M-1:0] x, y;
    x = rnd_elem();
    y = rnd_elem();
    chk_vec("R3 reference identity sanity", ref_mul(x, '1), x);
    run_mul("R3 x times ones", x, '1, -1);
    chk_vec("R3 x times ones returns x", result, x);
    run_mul("R3 ones times y", '1, y, -1);
    chk_vec("R3 ones times y returns y", result, y);
  endtask

  task automatic t_square();
    logic [M-1:0] a;
    a = rnd_elem();
    a[M-1] = 1'b1; a[0] = 1'b0;
    @(negedge clk);
    start = 1'b1; sq_sel = 1'b1; op_a = a;
    @(negedge clk);
    start = 1'b0; op_a = '0;
    chk_bit("R4 square done next cycle", done, 1'b1);
    chk_vec("R4 square rotation", result, {a[M-2:0], a[M-1]});
    chk_vec("R4 square equals self product", result, ref_mul(a, a));
    @(negedge clk);
    chk_bit("R5 square done one cycle", done, 1'b0);
  endtask

  task automatic t_hold();
    logic [M-1:0] keep;
    keep = result;
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      op_a = rnd_elem(); op_b = rnd_elem(); sq_sel = n[0];
    end
    chk_vec("R6 result held while idle", result, keep);
    chk_bit("R6 done low while idle", done, 1'b0);
  endtask

  task automatic t_busy_start();
    run_mul("R7 start during run ignored", rnd_elem(), rnd_elem(), 100);
    run_mul("R7 start near run end ignored", rnd_elem(), rnd_elem(), LAT - 3);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; finished = 0;
    t_reset();
    t_products();
    t_identity();
    t_square();
    t_hold();
    t_busy_start();
    t_hold();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule